// File: doc/BRIEF.md
# SPI Serial Clock Generator with Edge Strobes

This block turns the core clock into a serial clock for an SPI shifter. A transfer starts with a one-cycle `start` pulse while the block is idle. At that edge the block latches a 5-bit prescale code, the clock mode (polarity and phase), a sampling-edge override and the unit size. It then runs one serial clock period for each bit of the unit and produces one-cycle `launch` and `capture` strobes. The shifter uses those strobes to drive out and sample its data.

The prescale code has two ranges. With the top bit clear, the lower bits give the core-cycles-per-serial-clock ratio directly. With the top bit set, the ratio is twice the low four bits, which reaches even ratios up to 30. Any ratio below 2 is raised to 2. The override bit moves the capture strobe to the opposite serial-clock edge, which is needed at the fastest ratios. The unit is either one byte (8 bits) or one word (32 bits). `done` pulses when the last period of the unit ends.

Top module: `spi_clkgen`

## Requirements
- R1: With prescale bit 4 clear, the ratio N equals prescale[3:0] (0..15), and values 0 and 1 give N = 2.
- R2: With prescale bit 4 set, N equals 2 × prescale[3:0], so codes 16 and 17 give N = 2 and code 31 gives N = 30.
- R3: `busy` rises on the edge that accepts `start` and stays high for exactly N × bits core cycles. `done` is high for exactly one cycle, and that cycle is the first one in which `busy` is low.
- R4: `wordMode` = 1 selects a 32-bit unit and `wordMode` = 0 selects an 8-bit unit. Each bit takes one serial clock period of N core cycles.
- R5: When no transfer is active, `sclk` sits at the level of `cpol`, one cycle behind it.
- R6: In each period, `sclk` takes the non-idle level on a leading edge for floor(N/2) core cycles and then returns to idle for the rest of the period. The first leading edge comes one cycle after `busy` rises.
- R7: With `cpha` = 0, `launch` pulses on every trailing edge. With `cpha` = 1, `launch` pulses on every leading edge. This gives one launch per bit.
- R8: With `captureAlt` = 0, `capture` pulses on the edge opposite to launch. With `captureAlt` = 1, `capture` pulses on the launch edge. This gives one capture per bit.
- R9: A `start` pulse or a change of prescale, mode or unit size while `busy` is high has no effect on the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| prescale | input | 5 | Divide code, latched at start |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 1: launch on the leading edge |
| captureAlt | input | 1 | Moves capture to the other edge |
| wordMode | input | 1 | 1: 32-bit unit, 0: 8-bit unit |
| start | input | 1 | Begin a unit when idle |
| sclk | output | 1 | Serial clock |
| launch | output | 1 | Shift-out strobe, aligned to a sclk edge |
| capture | output | 1 | Sample strobe, aligned to a sclk edge |
| busy | output | 1 | Unit in progress |
| done | output | 1 | One-cycle end-of-unit pulse |

## Verification
The bench targets the ends of both prescale ranges: codes 0, 1, 16 and 17, which all clamp to 2, and code 31, which gives 30. A wrong decode there shows up as a wrong `busy` length. At N = 2 the trailing edge lands in the same cycle as the end of the unit. A design that drops that edge loses a strobe or leaves `sclk` at the wrong level. Every phase and override combination is checked by counting on which `sclk` level each strobe falls. Mid-transfer changes of the inputs and a second `start` are also driven, and they would show up as a changed period count or a restarted unit.

// File: rtl/spi_clkgen_pkg.sv
package spi_clkgen_pkg;
  localparam int PRE_W = 5;
  localparam int RATIO_W = PRE_W + 1;
  localparam int BYTE_BITS = 8;
  localparam int WORD_BYTES = 4;
  localparam int WORD_BITS = BYTE_BITS * WORD_BYTES;
  localparam int BIT_W = $clog2(WORD_BITS);

  typedef struct packed {
    logic load;
    logic active;
    logic lead;
    logic trail;
    logic finish;
  } tickT;

  function automatic logic [RATIO_W-1:0] ratioOf(input logic [PRE_W-1:0] code);
    logic [RATIO_W-1:0] raw;
    if (code[PRE_W-1]) raw = {1'b0, code[PRE_W-2:0], 1'b0};
    else               raw = {1'b0, code};
    if (raw < RATIO_W'(2)) raw = RATIO_W'(2);
    return raw;
  endfunction
endpackage

// File: rtl/spi_clkgen_ctrl.sv
module spi_clkgen_ctrl
  import spi_clkgen_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [PRE_W-1:0] prescale,
  input  logic             wordMode,
  input  logic             start,
  output tickT             tick
);
  logic               busyQ;
  logic [RATIO_W-1:0] cntQ;
  logic [RATIO_W-1:0] ratioQ;
  logic [BIT_W-1:0]   bitQ;
  logic [BIT_W-1:0]   lastBitQ;
  logic               periodEnd;

  assign periodEnd = (cntQ == ratioQ - RATIO_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      cntQ     <= '0;
      ratioQ   <= RATIO_W'(2);
      bitQ     <= '0;
      lastBitQ <= '0;
    end else if (start && !busyQ) begin
      busyQ    <= 1'b1;
      cntQ     <= '0;
      bitQ     <= '0;
      ratioQ   <= ratioOf(prescale);
      lastBitQ <= wordMode ? BIT_W'(WORD_BITS - 1) : BIT_W'(BYTE_BITS - 1);
    end else if (busyQ) begin
      if (periodEnd) begin
        cntQ <= '0;
        if (bitQ == lastBitQ) busyQ <= 1'b0;
        else                  bitQ  <= bitQ + BIT_W'(1);
      end else begin
        cntQ <= cntQ + RATIO_W'(1);
      end
    end
  end

  always_comb begin
    tick.load   = start && !busyQ;
    tick.active = busyQ;
    tick.lead   = busyQ && (cntQ == '0);
    tick.trail  = busyQ && (cntQ == (ratioQ >> 1));
    tick.finish = busyQ && periodEnd && (bitQ == lastBitQ);
  end
endmodule

// File: rtl/spi_clkgen_dp.sv
module spi_clkgen_dp
  import spi_clkgen_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  tickT tick,
  input  logic cpol,
  input  logic cpha,
  input  logic captureAlt,
  output logic sclk,
  output logic launch,
  output logic capture,
  output logic done
);
  logic cpolQ;
  logic launchOnLead;
  logic captureOnLead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpolQ         <= 1'b0;
      launchOnLead  <= 1'b0;
      captureOnLead <= 1'b1;
      sclk          <= 1'b0;
      launch        <= 1'b0;
      capture       <= 1'b0;
      done          <= 1'b0;
    end else begin
      if (tick.load) begin
        cpolQ         <= cpol;
        launchOnLead  <= cpha;
        captureOnLead <= ~(cpha ^ captureAlt);
      end
      if (!tick.active)    sclk <= cpol;
      else if (tick.lead)  sclk <= ~cpolQ;
      else if (tick.trail) sclk <= cpolQ;
      launch  <= (tick.lead && launchOnLead)  || (tick.trail && !launchOnLead);
      capture <= (tick.lead && captureOnLead) || (tick.trail && !captureOnLead);
      done    <= tick.finish;
    end
  end
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen
  import spi_clkgen_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [PRE_W-1:0] prescale,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             captureAlt,
  input  logic             wordMode,
  input  logic             start,
  output logic             sclk,
  output logic             launch,
  output logic             capture,
  output logic             busy,
  output logic             done
);
  tickT tick;

  spi_clkgen_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .prescale(prescale), .wordMode(wordMode),
    .start(start), .tick(tick)
  );

  spi_clkgen_dp u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .cpol(cpol), .cpha(cpha),
    .captureAlt(captureAlt), .sclk(sclk), .launch(launch),
    .capture(capture), .done(done)
  );

  assign busy = tick.active;
endmodule

// File: rtl/spi_clkgen_chk.sv
module spi_clkgen_chk (
  input logic clk,
  input logic rstN,
  input logic cpol,
  input logic start,
  input logic sclk,
  input logic launch,
  input logic capture,
  input logic busy,
  input logic done
);
  p_idle_level_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> (sclk == $past(cpol)));
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  p_strobe_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (launch || capture) |-> $past(busy));
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));
endmodule

bind spi_clkgen spi_clkgen_chk u_chk (
  .clk(clk), .rstN(rstN), .cpol(cpol), .start(start), .sclk(sclk),
  .launch(launch), .capture(capture), .busy(busy), .done(done)
);

// File: tb/spi_clkgen_tb.sv
module spi_clkgen_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] prescale = '0;
  logic cpol = 1'b0, cpha = 1'b0, captureAlt = 1'b0, wordMode = 1'b0, start = 1'b0;
  logic sclk, launch, capture, busy, done;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  spi_clkgen u_dut (
    .clk(clk), .rstN(rstN), .prescale(prescale), .cpol(cpol), .cpha(cpha),
    .captureAlt(captureAlt), .wordMode(wordMode), .start(start), .sclk(sclk),
    .launch(launch), .capture(capture), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int expRatio(input logic [4:0] code);
    int r;
    r = code[4] ? 2 * int'(code[3:0]) : int'(code);
    if (r < 2) r = 2;
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runUnit(input logic [4:0] pre, input logic pol, input logic pha,
                         input logic alt, input logic word, input logic disturb);
    int n, bits, idx, busyCyc, activeCyc, firstAct;
    int lchLead, lchTrail, capLead, capTrail, guard;
    n = expRatio(pre);
    bits = word ? 32 : 8;
    busyCyc = 0; activeCyc = 0; firstAct = -1;
    lchLead = 0; lchTrail = 0; capLead = 0; capTrail = 0; guard = 0;
    @(negedge clk);
    prescale = pre; cpol = pol; cpha = pha; captureAlt = alt; wordMode = word; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idx = 1;
    while (guard < 3000) begin
      if (busy) busyCyc++;
      if (busy && sclk != pol) begin
        activeCyc++;
        if (firstAct < 0) firstAct = idx;
      end
      if (launch && sclk != pol) lchLead++;
      if (launch && sclk == pol) lchTrail++;
      if (capture && sclk != pol) capLead++;
      if (capture && sclk == pol) capTrail++;
      if (done) break;
      if (disturb && idx == 5) begin
        prescale = ~pre; cpol = ~pol; cpha = ~pha; wordMode = ~word; start = 1'b1;
      end
      if (disturb && idx == 6) start = 1'b0;
      idx++; guard++;
      @(negedge clk);
    end
    // R1 R2 R4 R9: unit length from the decoded ratio and unit size
    check(pre[4] ? "R2 ratio x2 range" : "R1 ratio direct range", busyCyc, n * bits);
    check("R4 bits", lchLead + lchTrail, bits);
    check("R3 done with busy low", int'(busy), 0);
    check("R6 active cycles", activeCyc, bits * (n / 2));
    check("R6 first leading edge", firstAct, 2);
    check("R7 launch edge", pha ? lchLead : lchTrail, bits);
    check("R8 capture edge", ((pha ^ alt) == 1'b0) ? capLead : capTrail, bits);
    if (disturb) check("R9 disturbed unit length", busyCyc, n * bits);
    @(negedge clk);
    check("R3 done one cycle", int'(done), 0);
    check("R5 idle level", int'(sclk), int'(cpol));
    cpol = pol; cpha = pha; wordMode = word; prescale = pre;
    @(negedge clk);
    check("R5 idle after restore", int'(sclk), int'(pol));
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R3 reset busy", int'(busy), 0);
    check("R3 reset done", int'(done), 0);
    check("R7 reset launch", int'(launch), 0);
    check("R8 reset capture", int'(capture), 0);
    check("R5 reset sclk", int'(sclk), 0);
    // directed corners
    runUnit(5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    runUnit(5'd1,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    runUnit(5'd2,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    runUnit(5'd3,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    runUnit(5'd15, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    runUnit(5'd16, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    runUnit(5'd17, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    runUnit(5'd31, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    runUnit(5'd7,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    // random mix
    for (int i = 0; i < 30; i++) begin
      logic [4:0] p;
      logic [4:0] m;
      p = 5'($urandom_range(0, 31));
      m = 5'($urandom);
      runUnit(p, m[0], m[1], m[2], m[3], m[4]);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule